// File: doc/BRIEF.md
# Bus Activity Monitor with Watermark Interrupts

The block watches one or more channels of bus activity. Each channel accumulates a programmable weight for every event pulse it sees. At the end of a sampling period it folds the period total into an exponential moving average and restarts the count. A shared period generator divides an external base tick (nominally one per millisecond) into sampling periods of programmable length. All channels close their periods together.

Each channel compares the raw period total with an upper and a lower threshold. When a breach repeats for a programmed number of consecutive periods, the channel raises a status flag. The channel also compares the freshly updated average with its own pair of thresholds. Software programs the channels and reads the average through a flat register port with combinational reads. Status flags are cleared by writing ones to them. A summary word carries one pending bit per channel, and the OR of all pending bits drives the single interrupt output.

Top module: `amon_top`

Register map. The global word at 0x000 is the summary (read only); the word at 0x004 is the period limit. Channel c starts at 0x100 + 0x40·c and holds these words: 0x00 control, 0x04 status, 0x08 weight, 0x0C seed (write only), 0x10 average (read only), 0x14 raw upper threshold, 0x18 raw lower threshold, 0x1C average upper threshold, 0x20 average lower threshold.

## Requirements
- R1: After reset, every register reads 0, except that each channel's weight reads 1024. The interrupt output is 0.
- R2: The period limit register holds L. A sampling period ends on the (L+1)-th base tick after the previous end. Channel state that depends on the period changes only in that cycle.
- R3: While a channel runs, each cycle with its event input high adds the channel weight to the period total. The total saturates at all ones. An event in the cycle that closes a period counts toward the next period.
- R4: At a period end, a running channel replaces its average A with A + ((T − A) >>> (K+1)). T is the period total, K is control bits [12:10], and the difference is signed with an arithmetic shift. The period total then restarts.
- R5: Writing the seed word loads the average with the written value in the next cycle. A seed write takes priority over a period update in the same cycle.
- R6: With control bit 30 set, the raw upper streak works as follows. Once the period total exceeds the raw upper threshold in N+1 consecutive periods (N = control bits [28:26]), status bit 31 is set and the streak restarts from zero. Any period that does not breach resets the streak.
- R7: With control bit 29 set, the raw lower streak works the same way for totals strictly below the raw lower threshold. Its count is N = control bits [25:23], and it sets status bit 30.
- R8: At a period end, the new average is compared with the average thresholds. If control bit 21 is set and the new average is strictly above the average upper threshold, status bit 29 is set. If control bit 20 is set and the new average is strictly below the average lower threshold, status bit 28 is set.
- R9: Writing the status word clears each status bit written as 1 and leaves the others. Writing all ones clears everything. A set in the same cycle wins over a clear.
- R10: Summary bit 26−c is the OR of channel c's status bits. The interrupt output is the OR of all summary bits.
- R11: A channel runs only while control bit 31 (enable) and bit 18 (periodic sampling) are both set. Otherwise its events, period ends and streaks have no effect: the total and the streaks are held at zero, and the average keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle base time pulse |
| ev | input | NCH | Per-channel event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| irq | output | 1 | OR of all pending channel status |

## Verification
The bench goes after the average update with a negative difference and a shift larger than one. A design that truncates toward zero instead of flooring reads back one count too high. It also checks the strict comparison at the lower average threshold, where an inclusive compare would flag one period early. For the streaks, it interleaves a non-breaching period and then repeats breaches after a firing. A design that fails to restart or to reset its streak raises the flag too early or not at all. It also shows that a disabled channel and a half-enabled channel leave the average untouched, and that a partial status write leaves the other flags set.

// File: rtl/amon_pkg.sv
package amon_pkg;
   localparam int DW = 32;
   // control word bit positions
   localparam int B_EN        = 31;
   localparam int B_RUN_HI_EN = 30;
   localparam int B_RUN_LO_EN = 29;
   localparam int B_AVG_HI_EN = 21;
   localparam int B_AVG_LO_EN = 20;
   localparam int B_PER       = 18;
   localparam int K_LSB       = 10;
   localparam int NLO_LSB     = 23;
   localparam int NHI_LSB     = 26;
   // status word bit positions
   localparam int S_RUN_HI = 31;
   localparam int S_RUN_LO = 30;
   localparam int S_AVG_HI = 29;
   localparam int S_AVG_LO = 28;
   // channel word offsets
   localparam int O_CTRL = 0;
   localparam int O_STAT = 4;
   localparam int O_WGT  = 8;
   localparam int O_SEED = 12;
   localparam int O_AVG  = 16;
   localparam int O_RHI  = 20;
   localparam int O_RLO  = 24;
   localparam int O_AHI  = 28;
   localparam int O_ALO  = 32;
   // global word offsets
   localparam int G_SUM = 0;
   localparam int G_PER = 4;
endpackage

// File: rtl/amon_period.sv
module amon_period #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [PW-1:0] limit,
   output logic          pend
);
   logic [PW-1:0] run_q;

   assign pend = tick && (run_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= '0;
      else if (tick) run_q <= pend ? '0 : run_q + 1'b1;
   end
endmodule

// File: rtl/amon_streak.sv
module amon_streak #(
   parameter int NW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic          hit,
   input  logic [NW-1:0] need,
   output logic          fire
);
   logic [NW-1:0] run_q;

   assign fire = step && hit && (run_q == need);

   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= '0;
      else if (clr)  run_q <= '0;
      else if (step) run_q <= (hit && !fire) ? run_q + 1'b1 : '0;
   end
endmodule

// File: rtl/amon_chan.sv
module amon_chan
   import amon_pkg::*;
#(
   parameter int CW         = 32,
   parameter int KW         = 3,
   parameter int NW         = 3,
   parameter int OW         = 6,
   parameter int DEF_WEIGHT = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pend,
   input  logic          ev,
   input  logic          we,
   input  logic [OW-1:0] ofs,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] ctrl_q,
   output logic [DW-1:0] stat_q,
   output logic [CW-1:0] avg_q
);
   logic [CW-1:0] wgt_q, cnt_q, rhi_q, rlo_q, ahi_q, alo_q;
   logic          active, step, fire_hi, fire_lo;
   logic [KW-1:0] kval;
   logic [CW:0]   diff, shifted, sum;
   logic [CW-1:0] avg_nx, cnt_add;
   logic [DW-1:0] set_m, clr_m;

   function automatic logic hit_ofs(input logic [OW-1:0] o, input int w);
      return o == OW'(w);
   endfunction

   assign active = ctrl_q[B_EN] & ctrl_q[B_PER];
   assign step   = pend & active;
   assign kval   = ctrl_q[K_LSB +: KW];

   // exponential average step, signed difference, flooring shift
   assign diff    = {1'b0, cnt_q} - {1'b0, avg_q};
   assign shifted = $unsigned($signed(diff) >>> (int'(kval) + 1));
   assign avg_nx  = avg_q + shifted[CW-1:0];

   assign sum     = {1'b0, cnt_q} + {1'b0, wgt_q};
   assign cnt_add = sum[CW] ? '1 : sum[CW-1:0];

   amon_streak #(.NW(NW)) u_hi (
      .clk(clk), .rst_n(rst_n), .clr(!active), .step(step),
      .hit(cnt_q > rhi_q), .need(ctrl_q[NHI_LSB +: NW]), .fire(fire_hi));

   amon_streak #(.NW(NW)) u_lo (
      .clk(clk), .rst_n(rst_n), .clr(!active), .step(step),
      .hit(cnt_q < rlo_q), .need(ctrl_q[NLO_LSB +: NW]), .fire(fire_lo));

   always_comb begin
      set_m = '0;
      set_m[S_RUN_HI] = fire_hi & ctrl_q[B_RUN_HI_EN];
      set_m[S_RUN_LO] = fire_lo & ctrl_q[B_RUN_LO_EN];
      set_m[S_AVG_HI] = step & ctrl_q[B_AVG_HI_EN] & (avg_nx > ahi_q);
      set_m[S_AVG_LO] = step & ctrl_q[B_AVG_LO_EN] & (avg_nx < alo_q);
      clr_m = (we && hit_ofs(ofs, O_STAT)) ? wdata : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         stat_q <= '0;
         wgt_q  <= CW'(DEF_WEIGHT);
         cnt_q  <= '0;
         avg_q  <= '0;
         rhi_q  <= '0;
         rlo_q  <= '0;
         ahi_q  <= '0;
         alo_q  <= '0;
      end else begin
         stat_q <= (stat_q & ~clr_m) | set_m;
         if (!active)   cnt_q <= '0;
         else if (pend) cnt_q <= ev ? wgt_q : '0;
         else if (ev)   cnt_q <= cnt_add;
         if (we && hit_ofs(ofs, O_SEED)) avg_q <= wdata[CW-1:0];
         else if (step)                  avg_q <= avg_nx;
         if (we) begin
            if (hit_ofs(ofs, O_CTRL)) ctrl_q <= wdata;
            if (hit_ofs(ofs, O_WGT))  wgt_q  <= wdata[CW-1:0];
            if (hit_ofs(ofs, O_RHI))  rhi_q  <= wdata[CW-1:0];
            if (hit_ofs(ofs, O_RLO))  rlo_q  <= wdata[CW-1:0];
            if (hit_ofs(ofs, O_AHI))  ahi_q  <= wdata[CW-1:0];
            if (hit_ofs(ofs, O_ALO))  alo_q  <= wdata[CW-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if      (hit_ofs(ofs, O_CTRL)) rdata = ctrl_q;
      else if (hit_ofs(ofs, O_STAT)) rdata = stat_q;
      else if (hit_ofs(ofs, O_WGT))  rdata = DW'(wgt_q);
      else if (hit_ofs(ofs, O_AVG))  rdata = DW'(avg_q);
      else if (hit_ofs(ofs, O_RHI))  rdata = DW'(rhi_q);
      else if (hit_ofs(ofs, O_RLO))  rdata = DW'(rlo_q);
      else if (hit_ofs(ofs, O_AHI))  rdata = DW'(ahi_q);
      else if (hit_ofs(ofs, O_ALO))  rdata = DW'(alo_q);
   end
endmodule

// File: rtl/amon_top.sv
module amon_top
   import amon_pkg::*;
#(
   parameter int NCH        = 2,
   parameter int CW         = 32,
   parameter int PW         = 16,
   parameter int KW         = 3,
   parameter int NW         = 3,
   parameter int AW         = 10,
   parameter int CH_BASE    = 256,
   parameter int CH_STRIDE  = 64,
   parameter int SUM_TOP    = 26,
   parameter int DEF_WEIGHT = 1024
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           base_tick,
   input  logic [NCH-1:0] ev,
   input  logic           reg_we,
   input  logic [AW-1:0]  reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   output logic           irq
);
   localparam int OW = $clog2(CH_STRIDE);
   localparam int HW = AW - OW;

   if (CH_STRIDE != (1 << OW) || CH_STRIDE < 64) begin : g_bad_stride
      $error("channel stride must be a power of two of at least 64");
   end
   if (NW > 3 || KW > 8 || KW < 1) begin : g_bad_fields
      $error("field widths do not fit the control word");
   end
   if (CW > DW || CW < 8 || PW > DW) begin : g_bad_width
      $error("counter width out of range");
   end
   if (NCH < 1 || NCH > SUM_TOP + 1 || SUM_TOP >= DW) begin : g_bad_sum
      $error("channel count does not fit the summary word");
   end
   if (CH_BASE < 8 || CH_BASE + NCH * CH_STRIDE > (1 << AW)) begin : g_bad_map
      $error("channel windows do not fit the address space");
   end

   logic [PW-1:0]            per_lim_q;
   logic                     pend;
   logic [NCH-1:0]           ch_hit;
   logic [NCH-1:0][DW-1:0]   ch_rd, st_all, ctrl_all;
   logic [NCH-1:0][CW-1:0]   avg_all;
   logic [DW-1:0]            gsum;

   always_ff @(posedge clk) begin
      if (!rst_n) per_lim_q <= '0;
      else if (reg_we && reg_addr == AW'(G_PER)) per_lim_q <= reg_wdata[PW-1:0];
   end

   amon_period #(.PW(PW)) u_per (
      .clk(clk), .rst_n(rst_n), .tick(base_tick), .limit(per_lim_q), .pend(pend));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int BI = (CH_BASE + c * CH_STRIDE) >> OW;
      assign ch_hit[c] = reg_addr[AW-1:OW] == BI[HW-1:0];

      amon_chan #(
         .CW(CW), .KW(KW), .NW(NW), .OW(OW), .DEF_WEIGHT(DEF_WEIGHT)
      ) u_chan (
         .clk(clk), .rst_n(rst_n), .pend(pend), .ev(ev[c]),
         .we(reg_we && ch_hit[c]), .ofs(reg_addr[OW-1:0]), .wdata(reg_wdata),
         .rdata(ch_rd[c]), .ctrl_q(ctrl_all[c]), .stat_q(st_all[c]),
         .avg_q(avg_all[c]));
   end

   always_comb begin
      gsum = '0;
      for (int c = 0; c < NCH; c++) gsum[SUM_TOP - c] = |st_all[c];
   end

   assign irq = |gsum;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == AW'(G_SUM)) reg_rdata = gsum;
      if (reg_addr == AW'(G_PER)) reg_rdata = DW'(per_lim_q);
      for (int c = 0; c < NCH; c++)
         if (ch_hit[c]) reg_rdata = ch_rd[c];
   end
endmodule

// File: rtl/amon_chk.sv
module amon_chk #(
   parameter int AW      = 10,
   parameter int CW      = 32,
   parameter int NCH     = 2,
   parameter int CH_BASE = 256
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [AW-1:0]     reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              irq,
   input logic              pend,
   input logic [NCH*32-1:0] st_all,
   input logic [CW-1:0]     avg0,
   input logic              en0,
   input logic              per0
);
   localparam logic [AW-1:0] A_SEED0 = AW'(CH_BASE + 12);
   localparam logic [AW-1:0] A_STAT0 = AW'(CH_BASE + 4);

   logic        seed_wr;
   logic [31:0] st0;
   assign seed_wr = reg_we && reg_addr == A_SEED0;
   assign st0     = st_all[31:0];

   // R5: seed write lands in the average next cycle
   p_seed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seed_wr |=> avg0 == $past(reg_wdata[CW-1:0]));

   // R4: average moves only at a period end
   p_avg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !seed_wr) |=> $stable(avg0));

   // R11: a channel not running keeps its average
   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!(en0 && per0) && !seed_wr) |=> $stable(avg0));

   // R6: status flags rise only after a period end
   p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |=> ((st0 & ~$past(st0)) == 32'd0));

   // R9: writing all ones with no period end empties the status
   p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == A_STAT0 && reg_wdata == 32'hFFFF_FFFF && !pend)
      |=> st0 == 32'd0);

   // R10: interrupt follows pending status of any channel
   p_irq_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (st_all != '0));
endmodule

bind amon_top amon_chk #(
   .AW(AW), .CW(CW), .NCH(NCH), .CH_BASE(CH_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .irq(irq), .pend(pend), .st_all(st_all),
   .avg0(avg_all[0]), .en0(ctrl_all[0][31]), .per0(ctrl_all[0][18]));

// File: tb/amon_top_bench.sv
`timescale 1ns/1ps
module amon_top_bench;
   localparam logic [9:0] C0 = 10'h100, C1 = 10'h140;
   localparam logic [9:0] OCT = 10'h00, OST = 10'h04, OWG = 10'h08, OSD = 10'h0C,
                          OAV = 10'h10, ORH = 10'h14, ORL = 10'h18, OAH = 10'h1C,
                          OAL = 10'h20;
   localparam logic [31:0] EN = 32'h8000_0000, PER = 32'h0004_0000;

   typedef struct {
      logic [9:0]  addr;
      logic [31:0] val;
      bit          is_irq;
      string       tag;
   } item_t;

   logic        clk = 0, rst_n = 0, base_tick = 0, reg_we = 0, irq;
   logic [1:0]  ev = '0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   item_t       sb[$];
   int          n_chk = 0, n_err = 0, lim = 0;
   int          m_avg;
   bit          done = 0;

   always #4 clk = ~clk;

   amon_top u_amon_top (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .ev(ev),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq));

   // monitor: pops the expected item and compares the observed result
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         logic [31:0] got;
         it  = sb.pop_front();
         got = it.is_irq ? {31'd0, irq} : reg_rdata;
         n_chk++;
         if (got !== it.val) begin
            n_err++;
            $display("FAIL %s: addr=%h actual=%h expected=%h", it.tag, it.addr, got, it.val);
         end
      end
   end

   function automatic int nxt(input int a, input int t, input int k);
      return a + ((t - a) >>> (k + 1));
   endfunction

   task automatic wr(input logic [9:0] a, input logic [31:0] d);
      @(posedge clk); #1; reg_we = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1; reg_we = 0;
   endtask

   task automatic chk(input logic [9:0] a, input logic [31:0] v, input string tag);
      item_t it;
      @(posedge clk); #1; reg_addr = a;
      it.addr = a; it.val = v; it.is_irq = 0; it.tag = tag;
      sb.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic chk_irq(input logic v, input string tag);
      item_t it;
      @(posedge clk); #1;
      it.addr = '0; it.val = {31'd0, v}; it.is_irq = 1; it.tag = tag;
      sb.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic pulse_ev(input int c, input int n);
      if (n > 0) begin
         @(posedge clk); #1; ev[c] = 1'b1;
         repeat (n) @(posedge clk);
         #1; ev[c] = 1'b0;
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; base_tick = 1;
         @(posedge clk); #1; base_tick = 0;
      end
   endtask

   task automatic period(input int n0, input int n1);
      pulse_ev(0, n0);
      pulse_ev(1, n1);
      ticks(lim + 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      #1; rst_n = 1;

      // R1 reset state
      chk(C0 + OCT, 32'd0, "R1 ctrl0");
      chk(C0 + OWG, 32'd1024, "R1 weight0");
      chk(C1 + OWG, 32'd1024, "R1 weight1");
      chk(C0 + OAV, 32'd0, "R1 avg0");
      chk(10'h000, 32'd0, "R1 summary");
      chk(10'h004, 32'd0, "R1 period");
      chk_irq(1'b0, "R1 irq");

      // R5 seed, R11 idle channel
      wr(C0 + OSD, 32'd1000);
      chk(C0 + OAV, 32'd1000, "R5 seed load");
      pulse_ev(0, 4); ticks(1);
      chk(C0 + OAV, 32'd1000, "R11 disabled keeps avg");
      wr(C0 + OCT, EN);
      pulse_ev(0, 4); ticks(1);
      chk(C0 + OAV, 32'd1000, "R11 enable without periodic keeps avg");

      // R2, R3, R4: weight 16, K=0, periods of 2 ticks
      wr(C0 + OWG, 32'd16);
      chk(C0 + OWG, 32'd16, "R3 weight readback");
      wr(10'h004, 32'd1); lim = 1;
      wr(C0 + OCT, EN | PER);
      pulse_ev(0, 10); ticks(1);
      chk(C0 + OAV, 32'd1000, "R2 no update before last tick");
      ticks(1);
      m_avg = nxt(1000, 160, 0);
      chk(C0 + OAV, 32'(m_avg), "R4 R3 avg after 10 weighted events");
      period(3, 0);
      m_avg = nxt(m_avg, 48, 0);
      chk(C0 + OAV, 32'(m_avg), "R4 avg K=0 second period");
      wr(C0 + OCT, EN | PER | (32'd2 << 10));
      period(0, 0);
      m_avg = nxt(m_avg, 0, 2);
      chk(C0 + OAV, 32'(m_avg), "R4 avg floors negative step K=2");

      // R6 raw upper streak of 3
      wr(C0 + ORH, 32'd50);
      wr(C0 + OCT, EN | PER | (32'd2 << 10) | (32'd2 << 26) | (32'd1 << 30));
      period(4, 0); period(4, 0);
      chk(C0 + OST, 32'd0, "R6 no flag after two breaches");
      period(4, 0);
      chk(C0 + OST, 32'h8000_0000, "R6 flag after third breach");
      chk(10'h000, 32'h0400_0000, "R10 summary bit 26 for channel 0");
      chk_irq(1'b1, "R10 irq raised");
      wr(C0 + OST, 32'hFFFF_FFFF);
      chk(C0 + OST, 32'd0, "R9 clear all");
      chk_irq(1'b0, "R10 irq dropped");
      period(4, 0); period(4, 0);
      chk(C0 + OST, 32'd0, "R6 streak restarted after firing");
      period(0, 0); period(4, 0); period(4, 0);
      chk(C0 + OST, 32'd0, "R6 miss resets streak");
      period(4, 0);
      chk(C0 + OST, 32'h8000_0000, "R6 flag after fresh streak");
      wr(C0 + OST, 32'hFFFF_FFFF);

      // R7 raw lower streak of 1
      wr(C0 + ORL, 32'd20);
      wr(C0 + OCT, EN | PER | (32'd2 << 10) | (32'd1 << 29));
      period(1, 0);
      chk(C0 + OST, 32'h4000_0000, "R7 lower flag after one period");
      wr(C0 + OST, 32'hFFFF_FFFF);

      // R8 average thresholds
      wr(C0 + OCT, EN | PER | (32'd1 << 21));
      wr(C0 + OSD, 32'd0);
      wr(C0 + OAH, 32'd100);
      period(10, 0);
      chk(C0 + OST, 32'd0, "R8 avg 80 not above 100");
      period(10, 0);
      chk(C0 + OST, 32'h2000_0000, "R8 avg 120 above 100");
      wr(C0 + OST, 32'hFFFF_FFFF);
      wr(C0 + OCT, EN | PER | (32'd1 << 20));
      wr(C0 + OAL, 32'd50);
      wr(C0 + OSD, 32'd200);
      period(0, 0);
      chk(C0 + OST, 32'd0, "R8 avg 100 not below 50");
      period(0, 0);
      chk(C0 + OAV, 32'd50, "R4 avg 50");
      chk(C0 + OST, 32'd0, "R8 avg equal to lower threshold not flagged");

      // R9 partial clear
      wr(C0 + OCT, EN | PER | (32'd1 << 20) | (32'd1 << 29));
      period(0, 0);
      chk(C0 + OAV, 32'd25, "R4 avg 25");
      chk(C0 + OST, 32'h5000_0000, "R8 R7 two flags same period");
      wr(C0 + OST, 32'h1000_0000);
      chk(C0 + OST, 32'h4000_0000, "R9 partial clear keeps other flag");
      wr(C0 + OST, 32'hFFFF_FFFF);
      wr(C0 + OCT, 32'd0);

      // R10 second channel with default weight
      wr(C1 + OCT, EN | PER | (32'd1 << 30));
      period(2, 1);
      chk(C1 + OST, 32'h8000_0000, "R6 channel 1 upper flag");
      chk(C1 + OAV, 32'd512, "R3 default weight into channel 1 avg");
      chk(C0 + OAV, 32'd25, "R11 channel 0 avg unchanged while off");
      chk(10'h000, 32'h0200_0000, "R10 summary bit 25 for channel 1");
      chk_irq(1'b1, "R10 irq from channel 1");
      wr(C1 + OST, 32'hFFFF_FFFF);
      chk_irq(1'b0, "R10 irq cleared");

      repeat (3) @(posedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule